// File: doc/BRIEF.md
# Serial Identifier CRC Checker

This block protects a 64-bit device identifier with an 8-bit cyclic redundancy value. The identifier arrives one bit per accepted strobe, least significant bit first: an 8-bit family code, then a 48-bit serial number, then the 8-bit check byte. A start pulse clears the accumulator and the bit counter and opens a new run. Bits that arrive while no run is open are discarded.

In check mode the block captures the CRC of the 56-bit prefix when the 56th bit has been taken. After the 64th bit it gives a one-cycle verdict pulse and a held pass flag. The pass flag is set when the accumulator residue is zero. In generate mode the run ends after the 56th bit, and the captured prefix CRC is the check byte to append to the identifier. The running accumulator and the bit count can be read on the ports at all times.

Top module: `crc_id_checker`

## Requirements
- R1: After reset `crc_o` is 0, `bit_count_o` is 0, and `done_o`, `prefix_valid_o`, `check_valid_o` and `check_pass_o` are all 0.
- R2: A `start_i` pulse clears `crc_o`, `bit_count_o`, `done_o`, `check_pass_o` and `prefix_crc_o` to 0 in the next cycle and latches `gen_mode_i`. A bit strobed in the same cycle as `start_i` is discarded.
- R3: For each accepted bit b: fb = crc[0] XOR b; crc shifts right by one; if fb is 1, crc is XORed with 8'h8C (generator x^8+x^5+x^4+1, reflected). `bit_count_o` then rises by one. From a cleared accumulator, bit 1 gives 8'h8C, and a following bit 0 gives 8'h46.
- R4: Identifier bit i is fed as the i-th bit, with bits 7:0 as the family code and bits 55:8 as the serial number. One cycle after the 56th accepted bit, `prefix_valid_o` pulses for one cycle. In that cycle `bit_count_o` is 56 and `prefix_crc_o` holds the accumulator value. `prefix_crc_o` keeps that value until the next start. For family 8'h02 and serial 48'h00000001B81C the prefix CRC is 8'hA2.
- R5: In check mode, `check_valid_o` pulses for one cycle after the 64th accepted bit. `check_pass_o` is 1 exactly when the accumulator is zero at that point, and it holds until the next start. `done_o` becomes 1 at the same time.
- R6: An identifier with any single bit inverted in any of its 64 positions gives `check_pass_o` = 0.
- R7: In generate mode the run ends after the 56th bit. `done_o` becomes 1, `bit_count_o` stays at 56, and `crc_o` holds the prefix CRC. No `check_valid_o` pulse occurs.
- R8: Strobed bits while no run is open change neither `crc_o` nor `bit_count_o`. No run is open after reset, or after `done_o` has risen.
- R9: A start pulse during a run aborts it. No verdict is produced for the aborted run, and the new run counts from zero.
- R10: Cycles with `bit_valid_i` low hold `crc_o` and `bit_count_o`, so gaps between bits do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Opens a new run and clears the accumulator and the count |
| gen_mode_i | input | 1 | Sampled on start: 1 selects generate mode, 0 selects check mode |
| bit_valid_i | input | 1 | Strobe marking `bit_i` as valid this cycle |
| bit_i | input | 1 | Serial identifier bit |
| crc_o | output | 8 | Running accumulator |
| bit_count_o | output | 7 | Bits accepted in the current run |
| prefix_valid_o | output | 1 | One-cycle pulse after the 56th bit |
| prefix_crc_o | output | 8 | CRC captured over the 56-bit prefix |
| check_valid_o | output | 1 | One-cycle verdict pulse after the 64th bit |
| check_pass_o | output | 1 | Held verdict: residue was zero |
| done_o | output | 1 | Run finished; further bits are discarded |

## Verification
The properties assume that `start_i` is a single-cycle request and that the bench does not raise it before the internal synchronized reset has been released. The stimulus drives inputs one time unit after a rising edge and waits several cycles after reset before it pulses start. Bits strobed outside a run, bits coinciding with a start, and idle gaps are all legal input. The properties require them to leave the accumulator untouched, and the stimulus deliberately contains each case.

// File: rtl/crc_id_pkg.sv
package crc_id_pkg;

  localparam int unsigned CRC_W_DEF     = 8;
  localparam logic [7:0]  POLY_REFL_DEF = 8'h8C;
  localparam int unsigned DATA_BITS_DEF = 56;
  localparam int unsigned ID_BITS_DEF   = 64;

  typedef enum logic {
    MODE_CHECK = 1'b0,
    MODE_GEN   = 1'b1
  } id_mode_e;

endpackage

// File: rtl/crc_id_rst_sync.sv
module crc_id_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/crc_id_shift.sv
module crc_id_shift #(
  parameter int unsigned       CRC_W = crc_id_pkg::CRC_W_DEF,
  parameter logic [CRC_W-1:0]  POLY  = crc_id_pkg::POLY_REFL_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] crc_nxt_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] step;
  logic             fb;

  assign fb = crc_q[0] ^ bit_i;

  // one reflected shift step, unrolled per accumulator bit
  genvar gi;
  generate
    for (gi = 0; gi < CRC_W - 1; gi++) begin : g_tap
      assign step[gi] = crc_q[gi+1] ^ (fb & POLY[gi]);
    end
  endgenerate
  assign step[CRC_W-1] = fb & POLY[CRC_W-1];

  always_comb begin
    crc_d = crc_q;
    if (clr_i) begin
      crc_d = '0;
    end else if (en_i) begin
      crc_d = step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else begin
      crc_q <= crc_d;
    end
  end

  assign crc_o     = crc_q;
  assign crc_nxt_o = step;

endmodule

// File: rtl/crc_id_count.sv
module crc_id_count #(
  parameter int unsigned DATA_BITS = crc_id_pkg::DATA_BITS_DEF,
  parameter int unsigned ID_BITS   = crc_id_pkg::ID_BITS_DEF,
  localparam int unsigned CNT_W    = $clog2(ID_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_prefix_o,
  output logic             at_full_o
);

  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_ID   = CNT_W'(ID_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign at_prefix_o = (cnt_q == LAST_DATA);
  assign at_full_o   = (cnt_q == LAST_ID);

endmodule

// File: rtl/crc_id_seq.sv
module crc_id_seq
  import crc_id_pkg::*;
#(
  parameter int unsigned CRC_W = CRC_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic             accept_i,
  input  logic             at_prefix_i,
  input  logic             at_full_i,
  input  logic [CRC_W-1:0] crc_nxt_i,
  output logic             run_o,
  output logic             done_o,
  output logic             prefix_valid_o,
  output logic [CRC_W-1:0] prefix_crc_o,
  output logic             check_valid_o,
  output logic             check_pass_o
);

  logic             run_q,  run_d;
  id_mode_e         mode_q, mode_d;
  logic             done_q, done_d;
  logic             pv_q,   pv_d;
  logic [CRC_W-1:0] pcrc_q, pcrc_d;
  logic             cv_q,   cv_d;
  logic             pass_q, pass_d;

  always_comb begin
    run_d  = run_q;
    mode_d = mode_q;
    done_d = done_q;
    pv_d   = 1'b0;
    pcrc_d = pcrc_q;
    cv_d   = 1'b0;
    pass_d = pass_q;
    if (start_i) begin
      run_d  = 1'b1;
      mode_d = id_mode_e'(mode_i);
      done_d = 1'b0;
      pass_d = 1'b0;
      pcrc_d = '0;
    end else if (accept_i) begin
      if (at_prefix_i) begin
        pv_d   = 1'b1;
        pcrc_d = crc_nxt_i;
        if (mode_q == MODE_GEN) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end
      end
      if (at_full_i) begin
        cv_d   = 1'b1;
        pass_d = (crc_nxt_i == '0);
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_CHECK;
      done_q <= 1'b0;
      pv_q   <= 1'b0;
      pcrc_q <= '0;
      cv_q   <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_d;
      done_q <= done_d;
      pv_q   <= pv_d;
      pcrc_q <= pcrc_d;
      cv_q   <= cv_d;
      pass_q <= pass_d;
    end
  end

  assign run_o          = run_q;
  assign done_o         = done_q;
  assign prefix_valid_o = pv_q;
  assign prefix_crc_o   = pcrc_q;
  assign check_valid_o  = cv_q;
  assign check_pass_o   = pass_q;

endmodule

// File: rtl/crc_id_checker.sv
module crc_id_checker #(
  parameter int unsigned      CRC_W     = crc_id_pkg::CRC_W_DEF,
  parameter logic [CRC_W-1:0] POLY      = crc_id_pkg::POLY_REFL_DEF,
  parameter int unsigned      DATA_BITS = crc_id_pkg::DATA_BITS_DEF,
  parameter int unsigned      ID_BITS   = crc_id_pkg::ID_BITS_DEF,
  localparam int unsigned     CNT_W     = $clog2(ID_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             gen_mode_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CNT_W-1:0] bit_count_o,
  output logic             prefix_valid_o,
  output logic [CRC_W-1:0] prefix_crc_o,
  output logic             check_valid_o,
  output logic             check_pass_o,
  output logic             done_o
);

  logic             rst_sync_n;
  logic             seq_run;
  logic             accept;
  logic             at_prefix;
  logic             at_full;
  logic [CRC_W-1:0] crc_nxt;

  crc_id_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  // a bit is taken only inside an open run and never alongside a start
  assign accept = seq_run & bit_valid_i & ~start_i;

  crc_id_shift #(
    .CRC_W (CRC_W),
    .POLY  (POLY)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .clr_i     (start_i),
    .en_i      (accept),
    .bit_i     (bit_i),
    .crc_o     (crc_o),
    .crc_nxt_o (crc_nxt)
  );

  crc_id_count #(
    .DATA_BITS (DATA_BITS),
    .ID_BITS   (ID_BITS)
  ) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .clr_i       (start_i),
    .en_i        (accept),
    .cnt_o       (bit_count_o),
    .at_prefix_o (at_prefix),
    .at_full_o   (at_full)
  );

  crc_id_seq #(
    .CRC_W (CRC_W)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_sync_n),
    .start_i        (start_i),
    .mode_i         (gen_mode_i),
    .accept_i       (accept),
    .at_prefix_i    (at_prefix),
    .at_full_i      (at_full),
    .crc_nxt_i      (crc_nxt),
    .run_o          (seq_run),
    .done_o         (done_o),
    .prefix_valid_o (prefix_valid_o),
    .prefix_crc_o   (prefix_crc_o),
    .check_valid_o  (check_valid_o),
    .check_pass_o   (check_pass_o)
  );

endmodule

// File: rtl/crc_id_checker_sva.sv
module crc_id_checker_sva #(
  parameter int unsigned  CRC_W     = 8,
  parameter int unsigned  DATA_BITS = 56,
  parameter int unsigned  ID_BITS   = 64,
  localparam int unsigned CNT_W     = $clog2(ID_BITS + 1)
) (
  input logic             clk_i,
  input logic             rst_sync_n,
  input logic             start_i,
  input logic             bit_valid_i,
  input logic             seq_run,
  input logic [CRC_W-1:0] crc_o,
  input logic [CNT_W-1:0] bit_count_o,
  input logic             prefix_valid_o,
  input logic [CRC_W-1:0] prefix_crc_o,
  input logic             check_valid_o,
  input logic             check_pass_o,
  input logic             done_o
);

  localparam logic [CNT_W-1:0] PREFIX_CNT = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] FULL_CNT   = CNT_W'(ID_BITS);

  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    start_i |=> (crc_o == '0 && bit_count_o == '0 && !done_o && !check_pass_o));

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (seq_run && bit_valid_i && !start_i) |=> bit_count_o == $past(bit_count_o) + 1'b1);

  p_prefix_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    prefix_valid_o |-> (bit_count_o == PREFIX_CNT && prefix_crc_o == crc_o));

  p_verdict_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    check_valid_o |-> (bit_count_o == FULL_CNT && check_pass_o == (crc_o == '0) && done_o));

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    check_valid_o |=> !check_valid_o);

  p_gen_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (prefix_valid_o && done_o) |-> (bit_count_o == PREFIX_CNT && !check_valid_o));

  p_idle_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!seq_run && !start_i) |=> ($stable(crc_o) && $stable(bit_count_o)));

  p_gap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (seq_run && !bit_valid_i && !start_i) |=> ($stable(crc_o) && $stable(bit_count_o)));

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    bit_count_o <= FULL_CNT);

endmodule

bind crc_id_checker crc_id_checker_sva #(
  .CRC_W     (CRC_W),
  .DATA_BITS (DATA_BITS),
  .ID_BITS   (ID_BITS)
) u_sva (
  .clk_i          (clk_i),
  .rst_sync_n     (rst_sync_n),
  .start_i        (start_i),
  .bit_valid_i    (bit_valid_i),
  .seq_run        (seq_run),
  .crc_o          (crc_o),
  .bit_count_o    (bit_count_o),
  .prefix_valid_o (prefix_valid_o),
  .prefix_crc_o   (prefix_crc_o),
  .check_valid_o  (check_valid_o),
  .check_pass_o   (check_pass_o),
  .done_o         (done_o)
);

// File: tb/crc_id_checker_tb.sv
`timescale 1ns/1ps
module crc_id_checker_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i, gen_mode_i, bit_valid_i, bit_i;
  logic [7:0] crc_o, prefix_crc_o;
  logic [6:0] bit_count_o;
  logic       prefix_valid_o, check_valid_o, check_pass_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [9:0] exp_q[$];
  logic [9:0] mon_item;

  always #2.5 clk_i = ~clk_i;

  crc_id_checker u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .gen_mode_i     (gen_mode_i),
    .bit_valid_i    (bit_valid_i),
    .bit_i          (bit_i),
    .crc_o          (crc_o),
    .bit_count_o    (bit_count_o),
    .prefix_valid_o (prefix_valid_o),
    .prefix_crc_o   (prefix_crc_o),
    .check_valid_o  (check_valid_o),
    .check_pass_o   (check_pass_o),
    .done_o         (done_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model taken from the step rule of R3
  function automatic logic [7:0] ref_crc(input logic [63:0] bits, input int n);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = c[0] ^ bits[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] make_id(input logic [7:0] fam, input logic [47:0] ser);
    logic [63:0] pre;
    pre = {8'h00, ser, fam};
    return {ref_crc(pre, 56), ser, fam};
  endfunction

  task automatic drive(input logic s, input logic g, input logic v, input logic b);
    @(posedge clk_i);
    #1;
    start_i = s; gen_mode_i = g; bit_valid_i = v; bit_i = b;
  endtask

  // driver: pushes expected events, then feeds one run
  task automatic run_id(input logic [63:0] id, input logic g, input int nbits,
                        input int gap, input logic strobe_on_start);
    exp_q.push_back({2'd1, ref_crc(id, 56)});
    if (!g && nbits == 64)
      exp_q.push_back({2'd2, 7'd0, (ref_crc(id, 64) == 8'h00)});
    drive(1'b1, g, strobe_on_start, 1'b1);
    for (int i = 0; i < nbits; i++) begin
      drive(1'b0, 1'b0, 1'b1, id[i]);
      if (gap != 0 && (i % gap) == gap - 1) drive(1'b0, 1'b0, 1'b0, 1'b0);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) drive(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prefix_valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected prefix pulse", 64'(prefix_crc_o), 64'h0);
        else begin
          mon_item = exp_q.pop_front();
          check(mon_item[9:8] == 2'd1 && prefix_crc_o == mon_item[7:0], "R4 prefix crc",
                64'({2'd1, prefix_crc_o}), 64'(mon_item));
        end
      end
      if (check_valid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected verdict pulse", 64'(check_pass_o), 64'h0);
        else begin
          mon_item = exp_q.pop_front();
          check(mon_item[9:8] == 2'd2 && check_pass_o == mon_item[0], "R5 verdict",
                64'({2'd2, check_pass_o}), 64'({mon_item[9:8], mon_item[0]}));
        end
      end
    end
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] known, id;
    int pos[7];
    pos = '{0, 5, 8, 31, 55, 56, 63};
    start_i = 0; gen_mode_i = 0; bit_valid_i = 0; bit_i = 0;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    repeat (4) drive(1'b0, 1'b0, 1'b0, 1'b0);

    // R1 reset state
    check(crc_o == 8'h00, "R1 crc after reset", 64'(crc_o), 64'h0);
    check(bit_count_o == 7'd0 && !done_o, "R1 count/done after reset", 64'({bit_count_o, done_o}), 64'h0);
    check(!prefix_valid_o && !check_valid_o && !check_pass_o, "R1 flags after reset",
          64'({prefix_valid_o, check_valid_o, check_pass_o}), 64'h0);

    // R8 bits before any start are discarded
    repeat (5) drive(1'b0, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(crc_o == 8'h00 && bit_count_o == 7'd0, "R8 no run open", 64'({crc_o, bit_count_o}), 64'h0);

    // R3 single steps
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(crc_o == 8'h8C && bit_count_o == 7'd1, "R3 step with 1", 64'({crc_o, bit_count_o}), 64'({8'h8C, 7'd1}));
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(crc_o == 8'h46 && bit_count_o == 7'd2, "R3 step with 0", 64'({crc_o, bit_count_o}), 64'({8'h46, 7'd2}));
    // R10 idle cycles hold state
    repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(crc_o == 8'h46 && bit_count_o == 7'd2, "R10 hold in gap", 64'({crc_o, bit_count_o}), 64'({8'h46, 7'd2}));

    // R4/R5 known identifier; also aborts the partial run above (R9)
    known = {8'hA2, 48'h00000001B81C, 8'h02};
    run_id(known, 1'b0, 64, 0, 1'b0);
    check(prefix_crc_o == 8'hA2, "R4 known prefix crc", 64'(prefix_crc_o), 64'hA2);
    check(done_o && check_pass_o, "R5 pass held", 64'({done_o, check_pass_o}), 64'h3);
    check(bit_count_o == 7'd64 && crc_o == 8'h00, "R5 residue zero", 64'({crc_o, bit_count_o}), 64'(7'd64));

    // R8 bits after done are discarded
    repeat (4) drive(1'b0, 1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(crc_o == 8'h00 && bit_count_o == 7'd64, "R8 after done", 64'({crc_o, bit_count_o}), 64'(7'd64));

    // R6 single-bit errors
    foreach (pos[k]) begin
      run_id(known ^ (64'd1 << pos[k]), 1'b0, 64, 3, 1'b0);
      check(!check_pass_o && done_o, "R6 flipped bit fails", 64'({pos[k], check_pass_o}), 64'({pos[k], 1'b0}));
    end

    // R10 other identifiers with gaps
    id = make_id(8'h16, 48'h123456789ABC);
    run_id(id, 1'b0, 64, 2, 1'b0);
    check(check_pass_o, "R10 pass with gaps", 64'(check_pass_o), 64'h1);
    id = make_id(8'hFF, 48'hFFFFFFFFFFFF);
    run_id(id, 1'b0, 64, 5, 1'b0);
    check(check_pass_o, "R10 pass all ones", 64'(check_pass_o), 64'h1);

    // R2 strobe coinciding with start is discarded
    id = make_id(8'h16, 48'h00A5A5A5A5A5);
    run_id(id, 1'b0, 64, 0, 1'b1);
    check(check_pass_o && bit_count_o == 7'd64, "R2 start beats strobe", 64'({check_pass_o, bit_count_o}), 64'({1'b1, 7'd64}));

    // R7 generate mode
    id = make_id(8'h16, 48'h0000DEADBEEF);
    run_id(id, 1'b1, 56, 0, 1'b0);
    check(done_o && bit_count_o == 7'd56, "R7 gen ends at 56", 64'({done_o, bit_count_o}), 64'({1'b1, 7'd56}));
    check(crc_o == id[63:56] && prefix_crc_o == id[63:56], "R7 gen crc", 64'({crc_o, prefix_crc_o}), 64'({id[63:56], id[63:56]}));
    for (int i = 56; i < 64; i++) drive(1'b0, 1'b0, 1'b1, id[i]);
    repeat (2) drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(bit_count_o == 7'd56 && !check_pass_o, "R7 no verdict in gen", 64'({check_pass_o, bit_count_o}), 64'(7'd56));

    // R9 abort after the prefix point
    id = make_id(8'h33, 48'h0F0F0F0F0F0F);
    exp_q.push_back({2'd1, ref_crc(id, 56)});
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) drive(1'b0, 1'b0, 1'b1, id[i]);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(bit_count_o == 7'd0 && crc_o == 8'h00 && !done_o, "R9 abort clears", 64'({crc_o, bit_count_o}), 64'h0);
    id = make_id(8'h44, 48'h13579BDF0246);
    run_id(id, 1'b0, 64, 0, 1'b0);
    check(check_pass_o, "R9 restarted run passes", 64'(check_pass_o), 64'h1);

    repeat (3) drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(exp_q.size() == 0, "R9 all expected events seen", 64'(exp_q.size()), 64'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule